// File: doc/BRIEF.md
# Banked Program Counter Unit

This unit holds the instruction fetch address of a small 8-bit controller. The sequential counter covers only the low eleven address bits. The top address bit lives in the address register too, but it only changes on a long jump, a return, a vector or a reset. A separate bank flip-flop, set and cleared by dedicated strobes, supplies that top bit whenever a jump or call target is loaded. A return from the stack restores all twelve bits and leaves the flip-flop alone, so a later jump still uses whatever bank was last selected.

The instruction decoder drives one-cycle strobes:

- a long jump with an 11-bit target;
- an in-page branch with an 8-bit target;
- an increment;
- a 12-bit restore;
- reset and interrupt vector requests;
- the two bank selects.

The unit resolves the address strobes by a fixed priority. While the in-service input is high, the unit drives the top bit of the fetch address to zero, so interrupt code always runs from the lower bank. The held address and the flip-flop keep their values during that time.

Top module: `bank_pc_unit`

## Requirements
- R1: While `rst_n` is low, `fetchAddr` is 0x000 and `bankSel` is 0.
- R2: `selBank1` sets `bankSel` and `selBank0` clears it. If both are high in the same cycle, `selBank1` wins. Neither strobe changes `fetchAddr`.
- R3: `jumpLoad` loads address bits 10:0 from `jumpTarget` and bit 11 from the `bankSel` value held before that clock edge.
- R4: `incr` adds one to bits 10:0 only. 0x7FF is followed by 0x000, and 0xFFF is followed by 0x800.
- R5: `restoreLoad` loads all 12 bits from `restoreAddr` and leaves `bankSel` unchanged. A later jump uses that unchanged flip-flop.
- R6: `resetReq` loads 0x000 and clears `bankSel`. `extVecReq` loads 0x003 and `tmrVecReq` loads 0x007. When both vector requests arrive together, the external one wins.
- R7: While `inService` is 1, `fetchAddr[11]` reads 0 and bits 10:0 follow the held address. `bankSel` is unaffected. When `inService` drops, the held bit 11 reappears.
- R8: `branchLoad` replaces bits 7:0 with `branchTarget`. Bits 11:8 come from the held address after the increment rule of R4 is applied, so a branch at 0x1FF to 0x20 lands at 0x220, and one at 0xFFF to 0x05 lands at 0x805.
- R9: With several address strobes in one cycle, the priority from highest to lowest is: reset, external vector, timer vector, restore, jump, in-page branch, increment. Bank select strobes act in parallel with the address strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Synchronous restart request |
| extVecReq | input | 1 | External interrupt vector request |
| tmrVecReq | input | 1 | Timer interrupt vector request |
| selBank0 | input | 1 | Clear bank flip-flop |
| selBank1 | input | 1 | Set bank flip-flop |
| jumpLoad | input | 1 | Load long jump or call target |
| jumpTarget | input | 11 | Long jump target, bits 10:0 |
| branchLoad | input | 1 | Load in-page branch target |
| branchTarget | input | 8 | In-page target, bits 7:0 |
| incr | input | 1 | Sequential increment |
| restoreLoad | input | 1 | Restore address from stack |
| restoreAddr | input | 12 | Full restored address |
| inService | input | 1 | Interrupt service in progress |
| fetchAddr | output | 12 | Fetch address |
| bankSel | output | 1 | Bank flip-flop state |

## Verification
The bench builds the unit with its default parameters: an 11-bit counter, an 8-bit branch field and vectors at 3 and 7. With these values, the 0x7FF and 0xFFF wrap points and the 256-byte page ends (such as 0x1FF) can be reached in a few directed cycles. Directed sequences cover the return-then-jump bank hazard, forcing into the lower bank during service, and page-crossing branches. A run of random strobe mixes then exercises the priority order against the reference model on every clock.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_RST     = 3'd1,
    OP_VEXT    = 3'd2,
    OP_VTMR    = 3'd3,
    OP_RESTORE = 3'd4,
    OP_JUMP    = 3'd5,
    OP_BRANCH  = 3'd6,
    OP_INC     = 3'd7
  } pc_op_e;

  typedef struct packed {
    pc_op_e op;
    logic   bank;
  } pc_ctl_s;
endpackage

// File: rtl/bpc_ctrl.sv
module bpc_ctrl
  import bpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    resetReq,
  input  logic    extVecReq,
  input  logic    tmrVecReq,
  input  logic    selBank0,
  input  logic    selBank1,
  input  logic    jumpLoad,
  input  logic    branchLoad,
  input  logic    incr,
  input  logic    restoreLoad,
  output pc_ctl_s ctl
);
  logic bankQ;

  // Bank flip-flop: reset clears it, then set wins over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bankQ <= 1'b0;
    else if (resetReq) bankQ <= 1'b0;
    else if (selBank1) bankQ <= 1'b1;
    else if (selBank0) bankQ <= 1'b0;
  end

  // Fixed priority among the address strobes.
  always_comb begin
    ctl.bank = bankQ;
    if (resetReq)         ctl.op = OP_RST;
    else if (extVecReq)   ctl.op = OP_VEXT;
    else if (tmrVecReq)   ctl.op = OP_VTMR;
    else if (restoreLoad) ctl.op = OP_RESTORE;
    else if (jumpLoad)    ctl.op = OP_JUMP;
    else if (branchLoad)  ctl.op = OP_BRANCH;
    else if (incr)        ctl.op = OP_INC;
    else                  ctl.op = OP_HOLD;
  end

  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(selBank0 || selBank1 || resetReq) |=> $stable(bankQ));

  assert_bank_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (selBank1 && !resetReq) |=> bankQ);

  assert_reset_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> !bankQ);
endmodule

// File: rtl/bpc_datapath.sv
module bpc_datapath
  import bpc_pkg::*;
#(
  parameter int LOW_W   = 11,
  parameter int BR_W    = 8,
  parameter int EXT_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_ctl_s           ctl,
  input  logic [LOW_W-1:0]  jumpTarget,
  input  logic [BR_W-1:0]   branchTarget,
  input  logic [LOW_W:0]    restoreAddr,
  input  logic              inService,
  output logic [LOW_W:0]    fetchAddr
);
  localparam int ADDR_W = LOW_W + 1;
  localparam logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(EXT_VEC);
  localparam logic [ADDR_W-1:0] TMR_ADDR = ADDR_W'(TMR_VEC);

  logic [ADDR_W-1:0] pcQ, pcD, incNext, branchNext;

  // Only the low LOW_W bits count; the top bit is carried unchanged.
  assign incNext    = {pcQ[LOW_W], pcQ[LOW_W-1:0] + 1'b1};
  // The page comes from the already-incremented address.
  assign branchNext = {incNext[ADDR_W-1:BR_W], branchTarget};

  always_comb begin
    case (ctl.op)
      OP_RST:     pcD = '0;
      OP_VEXT:    pcD = EXT_ADDR;
      OP_VTMR:    pcD = TMR_ADDR;
      OP_RESTORE: pcD = restoreAddr;
      OP_JUMP:    pcD = {ctl.bank, jumpTarget};
      OP_BRANCH:  pcD = branchNext;
      OP_INC:     pcD = incNext;
      default:    pcD = pcQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcQ <= '0;
    else        pcQ <= pcD;
  end

  // Interrupt service confines fetches to the lower bank.
  assign fetchAddr = {pcQ[LOW_W] & ~inService, pcQ[LOW_W-1:0]};

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_INC |=> (pcQ[LOW_W-1:0] == $past(pcQ[LOW_W-1:0]) + 1'b1)
                         && (pcQ[LOW_W] == $past(pcQ[LOW_W])));

  assert_jump_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_JUMP |=> pcQ == {$past(ctl.bank), $past(jumpTarget)});

  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_RESTORE |=> pcQ == $past(restoreAddr));

  assert_ext_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_VEXT |=> pcQ == EXT_ADDR);

  assert_branch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.op == OP_BRANCH |=> pcQ[BR_W-1:0] == $past(branchTarget));

  always_comb begin
    if (rst_n && inService)
      assert_svc_low_bank_R7: assert (fetchAddr[LOW_W] == 1'b0);
  end
endmodule

// File: rtl/bank_pc_unit.sv
module bank_pc_unit
  import bpc_pkg::*;
#(
  parameter int LOW_W   = 11,
  parameter int BR_W    = 8,
  parameter int EXT_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resetReq,
  input  logic             extVecReq,
  input  logic             tmrVecReq,
  input  logic             selBank0,
  input  logic             selBank1,
  input  logic             jumpLoad,
  input  logic [LOW_W-1:0] jumpTarget,
  input  logic             branchLoad,
  input  logic [BR_W-1:0]  branchTarget,
  input  logic             incr,
  input  logic             restoreLoad,
  input  logic [LOW_W:0]   restoreAddr,
  input  logic             inService,
  output logic [LOW_W:0]   fetchAddr,
  output logic             bankSel
);
  pc_ctl_s ctl;

  bpc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .extVecReq(extVecReq),
    .tmrVecReq(tmrVecReq), .selBank0(selBank0), .selBank1(selBank1),
    .jumpLoad(jumpLoad), .branchLoad(branchLoad), .incr(incr),
    .restoreLoad(restoreLoad), .ctl(ctl)
  );

  bpc_datapath #(.LOW_W(LOW_W), .BR_W(BR_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .jumpTarget(jumpTarget),
    .branchTarget(branchTarget), .restoreAddr(restoreAddr),
    .inService(inService), .fetchAddr(fetchAddr)
  );

  assign bankSel = ctl.bank;
endmodule

// File: tb/tb_bank_pc_unit.sv
module tb_bank_pc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resetReq = 0, extVecReq = 0, tmrVecReq = 0, selBank0 = 0, selBank1 = 0;
  logic jumpLoad = 0, branchLoad = 0, incr = 0, restoreLoad = 0, inService = 0;
  logic [10:0] jumpTarget = '0;
  logic [7:0]  branchTarget = '0;
  logic [11:0] restoreAddr = '0;
  logic [11:0] fetchAddr;
  logic        bankSel;

  int checks = 0;
  int fails = 0;
  int pcM = 0;
  int bankM = 0;

  always #2 clk = ~clk;

  bank_pc_unit dut (
    .clk(clk), .rst_n(rst_n), .resetReq(resetReq), .extVecReq(extVecReq),
    .tmrVecReq(tmrVecReq), .selBank0(selBank0), .selBank1(selBank1),
    .jumpLoad(jumpLoad), .jumpTarget(jumpTarget), .branchLoad(branchLoad),
    .branchTarget(branchTarget), .incr(incr), .restoreLoad(restoreLoad),
    .restoreAddr(restoreAddr), .inService(inService),
    .fetchAddr(fetchAddr), .bankSel(bankSel)
  );

  function automatic int incM(int p);
    return (p & 'h800) | ((p + 1) & 'h7FF);
  endfunction

  task automatic compare(string tag);
    int expA;
    expA = inService ? (pcM & 'h7FF) : pcM;
    checks++;
    if (fetchAddr !== 12'(expA) || bankSel !== 1'(bankM)) begin
      fails++;
      $display("FAIL %s: addr=%03h bank=%0d expected addr=%03h bank=%0d",
               tag, fetchAddr, bankSel, expA, bankM);
    end
  endtask

  task automatic clearIn();
    resetReq = 0; extVecReq = 0; tmrVecReq = 0; selBank0 = 0; selBank1 = 0;
    jumpLoad = 0; branchLoad = 0; incr = 0; restoreLoad = 0;
  endtask

  // Apply one clock with the currently driven inputs, then compare.
  task automatic cycle(string tag);
    if (resetReq)         pcM = 0;
    else if (extVecReq)   pcM = 3;
    else if (tmrVecReq)   pcM = 7;
    else if (restoreLoad) pcM = int'(restoreAddr);
    else if (jumpLoad)    pcM = bankM * 2048 + int'(jumpTarget);
    else if (branchLoad)  pcM = (incM(pcM) & 'hF00) | int'(branchTarget);
    else if (incr)        pcM = incM(pcM);
    if (resetReq)      bankM = 0;
    else if (selBank1) bankM = 1;
    else if (selBank0) bankM = 0;
    @(posedge clk);
    #1;
    compare(tag);
    clearIn();
  endtask

  task automatic jumpTo(int t, string tag);
    jumpLoad = 1; jumpTarget = 11'(t); cycle(tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3;
    compare("R1 reset state");
    #4 rst_n = 1;
    @(posedge clk); #1;

    incr = 1; cycle("R4 increment");
    selBank1 = 1; cycle("R2 set bank, address held");
    jumpTo('h7FF, "R3 jump with bank 1");
    incr = 1; cycle("R4 wrap 0xFFF to 0x800");
    selBank0 = 1; selBank1 = 1; cycle("R2 both selects, set wins");
    selBank0 = 1; cycle("R2 clear bank");
    jumpTo('h7FF, "R3 jump with bank 0");
    incr = 1; cycle("R4 wrap 0x7FF to 0x000");

    selBank1 = 1; jumpTo('h100, "R3 jump uses old bank");
    restoreLoad = 1; restoreAddr = 12'h123; cycle("R5 restore keeps bank");
    jumpTo('h010, "R5 jump after return stays in bank 1");
    inService = 1; #1; compare("R7 forced to lower bank");
    incr = 1; cycle("R7 increment during service");
    inService = 0; #1; compare("R7 upper bank visible again");
    inService = 1;
    extVecReq = 1; cycle("R6 external vector");
    tmrVecReq = 1; cycle("R6 timer vector");
    extVecReq = 1; tmrVecReq = 1; cycle("R6 external beats timer");
    inService = 0;

    selBank0 = 1; jumpTo('h1FF, "R3 jump to page end");
    branchLoad = 1; branchTarget = 8'h20; cycle("R8 branch crosses page");
    jumpTo('h7FF, "R3 setup");
    branchLoad = 1; branchTarget = 8'h44; cycle("R8 branch at 0x7FF");
    selBank1 = 1; cycle("R2 setup");
    jumpTo('h7FF, "R3 setup");
    branchLoad = 1; branchTarget = 8'h05; cycle("R8 branch at 0xFFF");

    jumpLoad = 1; jumpTarget = 11'h055; incr = 1; branchLoad = 1; cycle("R9 jump over branch and increment");
    restoreLoad = 1; restoreAddr = 12'hABC; jumpLoad = 1; cycle("R9 restore over jump");
    resetReq = 1; extVecReq = 1; selBank1 = 1; restoreLoad = 1; cycle("R6 R9 reset over all");

    for (int i = 0; i < 600; i++) begin
      resetReq    = ($urandom % 40) == 0;
      extVecReq   = ($urandom % 12) == 0;
      tmrVecReq   = ($urandom % 12) == 0;
      restoreLoad = ($urandom % 8) == 0;
      restoreAddr = 12'($urandom);
      jumpLoad    = ($urandom % 4) == 0;
      jumpTarget  = 11'($urandom);
      branchLoad  = ($urandom % 4) == 0;
      branchTarget = 8'($urandom);
      incr        = ($urandom % 2) == 0;
      selBank0    = ($urandom % 5) == 0;
      selBank1    = ($urandom % 5) == 0;
      inService   = ($urandom % 3) == 0;
      cycle("R9 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule